// File: doc/BRIEF.md
# Partitionable SIMD Integer ALU

This block is a 32-bit integer ALU whose carry chain can be broken at byte boundaries chosen per operation. It can treat its operands as a single 32-bit word, as a pair of independent 16-bit halves, or as four independent bytes. Each active lane of an add or subtract also reports its own carry or borrow bit. A packed-pixel datapath uses these per-lane bits to act on several small values in one issue slot, for example when it compares four 8-bit pixels against a threshold at once.

The arithmetic is a single level of logic. A parameter selects an optional output register, which is on by default. Each operation, in every lane layout, gives its result one clock after its operands are presented, or in the same cycle when the register is removed. The bitwise operations span all 32 bits whatever the layout.

Top module: `psimd_alu`

## Requirements
- R1: Operation code 0 adds. In layout 0 (one 32-bit lane) the result is (A+B) mod 2^32, and flag bit 3 holds the carry out of bit 31.
- R2: Operation code 1 subtracts. Each lane gives (A-B) modulo its lane width, and the lane's flag is 1 exactly when the unsigned lane value of A is below that of B.
- R3: In layout 2 (four 8-bit lanes), no carry or borrow crosses a byte boundary. Flag bit i belongs to byte i (bits 8i+7..8i).
- R4: In layout 0 only flag bit 3 can be set, and flag bits 2..0 read 0. Layout code 3 behaves exactly like layout 0.
- R5: In layout 1 (two 16-bit lanes) the halves are independent. The low half reports in flag bit 1 and the high half in flag bit 3. Flag bits 0 and 2 read 0.
- R6: Operation codes 2, 3 and 4 give the bitwise AND, OR and XOR of all 32 bits in every layout, with all four flags 0.
- R7: Operation codes 5, 6 and 7 give a result of 0 and flags of 0.
- R8: With the output register fitted (the default), the result and flags for operands presented in one cycle appear after the next rising clock edge and hold until the edge after that.
- R9: While the active-low reset is asserted, the registered result and flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (subtrahend for subtract) |
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5..7 unused |
| part_mode | input | 2 | Lane layout: 0 one 32-bit, 1 two 16-bit, 2 four 8-bit, 3 same as 0 |
| result | output | 32 | Lane results packed in operand order |
| lane_flags | output | 4 | Per-lane carry (add) or borrow (subtract), at the top byte of each lane |

## Verification
On every cycle, the assertions check the positions where flags may appear in the 32-bit and 16-bit layouts, the clearing of flags for bitwise operations, the XOR result, and the independent sum of the lowest byte in the four-lane layout. They compare each operand set with the result one register later. Only the bench's scenarios show that the carry and borrow values are correct. The same holds for borrow detection across a 16-bit boundary, reserved layout code 3, the unused operation codes and the reset value. The bench runs a reference model that walks the lanes, on directed extreme operands and on random operands in every layout.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
   localparam int unsigned SLICES = 4;
   localparam int unsigned OP_W   = 3;
   localparam int unsigned PM_W   = 2;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4
   } alu_op_e;

   typedef enum logic [PM_W-1:0] {
      PM_W32 = 2'd0,
      PM_W16 = 2'd1,
      PM_W8  = 2'd2,
      PM_RSV = 2'd3
   } part_e;
endpackage

// File: rtl/psimd_lane_map.sv
// Turns the layout code into per-slice carry cuts and lane-top markers.
module psimd_lane_map
   import psimd_pkg::*;
(
   input  logic [PM_W-1:0]   mode,
   output logic [SLICES-1:0] cut,
   output logic [SLICES-1:0] lane_top
);
   always_comb begin
      int grp;
      case (mode)
         PM_W16:  grp = 2;
         PM_W8:   grp = 1;
         default: grp = SLICES;   // R4: reserved code folds to full width
      endcase
      for (int i = 0; i < SLICES; i++) begin
         cut[i]      = ((i % grp) == 0);
         lane_top[i] = ((i % grp) == (grp - 1));
      end
   end
endmodule

// File: rtl/psimd_slice.sv
// One byte-wide adder slice; inv_b turns it into the A + ~B half of a subtract.
module psimd_slice #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         inv_b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] acc;
   assign acc  = {1'b0, a} + {1'b0, b ^ {W{inv_b}}} + {{W{1'b0}}, cin};
   assign sum  = acc[W-1:0];
   assign cout = acc[W];
endmodule

// File: rtl/psimd_alu.sv
module psimd_alu
   import psimd_pkg::*;
#(
   parameter int unsigned LANE_W  = 8,
   parameter int unsigned REG_OUT = 1,
   localparam int unsigned DATA_W = SLICES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [PM_W-1:0]   part_mode,
   output logic [DATA_W-1:0] result,
   output logic [SLICES-1:0] lane_flags
);
   generate
      if (LANE_W < 1) begin : g_bad_w
         $error("psimd_alu: LANE_W must be at least 1");
      end
      if (REG_OUT > 1) begin : g_bad_reg
         $error("psimd_alu: REG_OUT must be 0 or 1");
      end
   endgenerate

   logic is_sub, is_arith;
   assign is_sub   = (op_sel == OP_SUB);
   assign is_arith = (op_sel == OP_ADD) || is_sub;

   logic [SLICES-1:0] cut, lane_top, cout, cin;
   logic [DATA_W-1:0] arith_sum;

   psimd_lane_map u_map (
      .mode     (part_mode),
      .cut      (cut),
      .lane_top (lane_top)
   );

   genvar gi;
   generate
      for (gi = 0; gi < SLICES; gi++) begin : g_slice
         if (gi == 0) begin : g_first
            assign cin[gi] = is_sub;
         end else begin : g_rest
            // R3/R5: a cut slice restarts the lane with the subtract carry-in
            assign cin[gi] = cut[gi] ? is_sub : cout[gi-1];
         end
         psimd_slice #(.W(LANE_W)) u_slice (
            .a     (op_a[gi*LANE_W +: LANE_W]),
            .b     (op_b[gi*LANE_W +: LANE_W]),
            .inv_b (is_sub),
            .cin   (cin[gi]),
            .sum   (arith_sum[gi*LANE_W +: LANE_W]),
            .cout  (cout[gi])
         );
      end
   endgenerate

   // Carry out of a lane top is a carry for add; its absence is a borrow for subtract.
   logic [SLICES-1:0] flag_nxt;
   assign flag_nxt = is_arith ? (lane_top & (is_sub ? ~cout : cout)) : '0;

   logic [DATA_W-1:0] res_nxt;
   always_comb begin
      case (op_sel)
         OP_ADD, OP_SUB: res_nxt = arith_sum;
         OP_AND:         res_nxt = op_a & op_b;
         OP_OR:          res_nxt = op_a | op_b;
         OP_XOR:         res_nxt = op_a ^ op_b;
         default:        res_nxt = '0;   // R7
      endcase
   end

   generate
      if (REG_OUT != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               result     <= '0;
               lane_flags <= '0;
            end else begin
               result     <= res_nxt;
               lane_flags <= flag_nxt;
            end
         end
      end else begin : g_comb
         assign result     = res_nxt;
         assign lane_flags = flag_nxt;
      end
   endgenerate
endmodule

// File: rtl/psimd_alu_chk.sv
module psimd_alu_chk
   import psimd_pkg::*;
#(
   parameter int unsigned LANE_W  = 8,
   parameter int unsigned REG_OUT = 1,
   localparam int unsigned DATA_W = SLICES * LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [OP_W-1:0]   op_sel,
   input logic [PM_W-1:0]   part_mode,
   input logic [DATA_W-1:0] result,
   input logic [SLICES-1:0] lane_flags
);
   logic [DATA_W-1:0] ob_a, ob_b;
   logic [OP_W-1:0]   ob_op;
   logic [PM_W-1:0]   ob_md;
   logic              ob_vld;

   generate
      if (REG_OUT != 0) begin : g_obs_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ob_a <= '0; ob_b <= '0; ob_op <= '0; ob_md <= '0; ob_vld <= 1'b0;
            end else begin
               ob_a <= op_a; ob_b <= op_b; ob_op <= op_sel; ob_md <= part_mode; ob_vld <= 1'b1;
            end
         end
      end else begin : g_obs_comb
         assign ob_a = op_a; assign ob_b = op_b; assign ob_op = op_sel;
         assign ob_md = part_mode; assign ob_vld = 1'b1;
      end
   endgenerate

   logic ob_logic;
   assign ob_logic = (ob_op == OP_AND) || (ob_op == OP_OR) || (ob_op == OP_XOR);

   a_r6_logic_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_vld && ob_logic) |-> (lane_flags == '0));

   a_r6_xor_word: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_vld && ob_op == OP_XOR) |-> (result == (ob_a ^ ob_b)));

   a_r5_pair_flag_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_vld && ob_md == PM_W16) |-> (!lane_flags[0] && !lane_flags[2]));

   a_r4_wide_flag_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_vld && (ob_md == PM_W32 || ob_md == PM_RSV)) |-> (lane_flags[2:0] == 3'b000));

   a_r3_byte0_add: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_vld && ob_md == PM_W8 && ob_op == OP_ADD)
         |-> (result[LANE_W-1:0] == LANE_W'(ob_a[LANE_W-1:0] + ob_b[LANE_W-1:0])));
endmodule

bind psimd_alu psimd_alu_chk #(.LANE_W(LANE_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/psimd_alu_test.sv
`timescale 1ns/1ps
module psimd_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a = 32'hFFFF_FFFF, b = 32'h0000_0001;
   logic [2:0]  op = 3'd0;
   logic [1:0]  md = 2'd0;
   logic [31:0] result;
   logic [3:0]  lane_flags;

   int total = 0, bad = 0;
   logic [31:0] exp_r_q[$];
   logic [3:0]  exp_f_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   psimd_alu uut (
      .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .op_sel(op),
      .part_mode(md), .result(result), .lane_flags(lane_flags)
   );

   task automatic chk(string tag, logic [31:0] er, logic [3:0] ef);
      total++;
      if (result !== er || lane_flags !== ef) begin
         bad++;
         $display("FAIL %s result=%h exp=%h flags=%b exp=%b", tag, result, er, lane_flags, ef);
      end
   endtask

   // Lane-by-lane reference built from the requirement text.
   function automatic void ref_model(input logic [31:0] ra, rb, input logic [2:0] rop,
                                     input logic [1:0] rmd,
                                     output logic [31:0] rr, output logic [3:0] rf);
      int grp, w;
      logic [63:0] mask, av, bv, s;
      rr = '0; rf = '0;
      case (rop)
         3'd2: rr = ra & rb;
         3'd3: rr = ra | rb;
         3'd4: rr = ra ^ rb;
         3'd0, 3'd1: begin
            grp = (rmd == 2'd1) ? 2 : (rmd == 2'd2) ? 1 : 4;
            w = 8 * grp;
            mask = (64'd1 << w) - 64'd1;
            for (int l = 0; l < 4 / grp; l++) begin
               av = ({32'd0, ra} >> (w * l)) & mask;
               bv = ({32'd0, rb} >> (w * l)) & mask;
               if (rop == 3'd0) begin
                  s = av + bv;
                  rf[(l + 1) * grp - 1] = s[w];
               end else begin
                  s = av - bv;
                  rf[(l + 1) * grp - 1] = (av < bv);
               end
               rr = rr | 32'((s & mask) << (w * l));
            end
         end
         default: ;
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] top_, logic [1:0] tmd);
      if (top_ >= 3'd5) return "R7";
      if (top_ >= 3'd2) return "R6";
      if (tmd == 2'd2)  return "R3";
      if (tmd == 2'd1)  return "R5";
      if (tmd == 2'd3)  return "R4";
      if (top_ == 3'd1) return "R2";
      return "R1";
   endfunction

   // Drive on the falling edge; the previous operation's outputs are visible now.
   task automatic apply(logic [31:0] na, nb, logic [2:0] nop, logic [1:0] nmd);
      logic [31:0] pr, er;
      logic [3:0]  pf, ef;
      string       pt;
      bit          have;
      @(negedge clk);
      have = (exp_r_q.size() > 0);
      if (have) begin
         pr = exp_r_q.pop_front(); pf = exp_f_q.pop_front(); pt = tag_q.pop_front();
         chk(pt, pr, pf);
      end
      a = na; b = nb; op = nop; md = nmd;
      ref_model(na, nb, nop, nmd, er, ef);
      exp_r_q.push_back(er); exp_f_q.push_back(ef); tag_q.push_back(tag_of(nop, nmd));
      #1;
      if (have) chk("R8 hold", pr, pf);   // new inputs must not show before the edge
   endtask

   task automatic flush();
      @(negedge clk);
      while (exp_r_q.size() > 0) chk(tag_q.pop_front(), exp_r_q.pop_front(), exp_f_q.pop_front());
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset", 32'h0, 4'h0);
      @(negedge clk) rst_n = 1'b1;

      apply(32'hFFFF_FFFF, 32'h0000_0001, 3'd0, 2'd0);  // R1 wrap, carry in bit 3
      apply(32'h1234_5678, 32'h1111_1111, 3'd0, 2'd0);  // R1 no carry
      apply(32'hFF01_FF80, 32'h01FF_0180, 3'd0, 2'd2);  // R3 every byte carries
      apply(32'h00FF_00FF, 32'h0001_0001, 3'd0, 2'd2);  // R3 carry must not cross
      apply(32'h0001_0005, 32'h0002_0003, 3'd1, 2'd1);  // R5 high half borrows
      apply(32'h0000_0000, 32'h0000_0001, 3'd1, 2'd1);  // R5 low borrow stays low
      apply(32'h0000_0000, 32'h0000_0001, 3'd1, 2'd3);  // R4 reserved acts as 32-bit
      apply(32'h0102_0304, 32'h0203_0203, 3'd1, 2'd2);  // R2 mixed byte borrows
      apply(32'h5555_5555, 32'h5555_5555, 3'd1, 2'd0);  // R2 equal, no borrow
      apply(32'hF0F0_FFFF, 32'h0FF0_0001, 3'd2, 2'd2);  // R6 AND
      apply(32'hF0F0_FFFF, 32'h0FF0_0001, 3'd3, 2'd1);  // R6 OR
      apply(32'hFFFF_FFFF, 32'h0000_0001, 3'd4, 2'd0);  // R6 XOR
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd5, 2'd0);  // R7 unused codes
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, 2'd2);  // R7

      for (int m = 0; m < 4; m++)
         for (int o = 0; o < 8; o++)
            for (int k = 0; k < 40; k++)
               apply($urandom, (k % 5 == 0) ? 32'hFFFF_FFFF : $urandom, 3'(o), 2'(m));
      flush();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule